// File: doc/BRIEF.md
# Recirculating Serial Video Output Port

This block is one serial read port of a video field store. A wide word from the memory array goes first into a holding latch. The latch is loaded when the RAM-enable signal falls while the port-select mode input is set. A separate read-transfer strobe later copies the latch into a rotating register of `DEPTH` nibbles, each `NIB_W` bits wide. The output shows one nibble at a time. Each rising edge of the port's shift clock moves on to the next nibble.

The latch sits between the memory and the rotating register, so memory reads and the serial stream are independent. A new word can be fetched while the current block is still being shifted out. The moment the transfer strobe falls marks the start of each output block. If no transfer arrives, the register keeps rotating and repeats the same nibbles in the same order.

All strobe and clock inputs are sampled in one system clock domain, and a registered edge detector finds their edges. An active-low output enable either presents the nibble or releases the output. The released state is modelled as a cleared valid flag, with the data forced to zero.

Top module: `recirc_serial_outport`

## Requirements
- R1: After reset the rotating register and the latch hold all zeros, so with `oe_n` low, `nib_out` reads 0 and `nib_valid` reads 1.
- R2: A falling edge of `ram_en` sampled while `port_sel` is 1 loads `mem_word` into the holding latch on that clock edge.
- R3: A falling edge of `ram_en` while `port_sel` is 0 leaves the latch unchanged.
- R4: A falling edge of `xfer_n` copies the latch into the rotating register. One clock later `nib_out` shows latch bits [3:0] (nibble 0).
- R5: Each rising edge of `shift_clk` advances the output. After k shift edges following a transfer, `nib_out` shows latch bits [4k+3:4k].
- R6: After 16 shift edges with no transfer, the output wraps back to nibble 0 and repeats the same 16 nibbles in cyclic order.
- R7: A transfer in the middle of a block restarts the output at nibble 0 of the current latch contents.
- R8: If a transfer edge and a shift edge are seen in the same system clock cycle, the transfer wins and nibble 0 is shown. The shift is dropped.
- R9: Loading the latch does not change the rotating register or `nib_out`.
- R10: With `oe_n` high, `nib_valid` is 0 and `nib_out` is 0. Shift edges while disabled still advance the register.
- R11: A level held over many clock cycles counts as one edge. Holding `shift_clk` high advances exactly one nibble, and an input already at its active level when reset is released produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_word | input | NIB_W*DEPTH | Word read from the memory array |
| ram_en | input | 1 | RAM-enable; its falling edge can load the latch |
| port_sel | input | 1 | Mode input; 1 selects this port for a memory read |
| xfer_n | input | 1 | Read-transfer strobe; its falling edge copies latch to register |
| shift_clk | input | 1 | Serial shift clock; rising edge advances one nibble |
| oe_n | input | 1 | Active-low output enable |
| nib_out | output | NIB_W | Current output nibble, 0 when disabled |
| nib_valid | output | 1 | 1 when the output is driven |

## Verification
The bench builds the block with its default parameters: 4-bit nibbles and 16 stages, giving a 64-bit word. At that depth a full wrap takes only sixteen shift pulses. This puts the recirculation boundary, a mid-block restart and a long run of repeated nibbles within a few hundred clock cycles. The chosen words give each nibble position a distinct value, so the check at every step confirms both the order of the output and the wrap point.

// File: rtl/rsop_pkg.sv
package rsop_pkg;

  // Edge found between the previous sample and the current level.
  function automatic logic edge_seen(input logic prev, input logic cur,
                                     input logic rising);
    return rising ? (!prev && cur) : (prev && !cur);
  endfunction

  // Index of the stage feeding stage i in a ring of n stages.
  function automatic int ring_src(input int i, input int n);
    return (i + 1) % n;
  endfunction

endpackage

// File: rtl/rsop_edge.sv
module rsop_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic ev
);
  logic prev_q;

  // Reset to the level just after an edge, so an input already
  // at its active level on reset release gives no event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RISING;
    else        prev_q <= lvl;
  end

  assign ev = rsop_pkg::edge_seen(prev_q, lvl, RISING);

  // R11
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> !ev);

endmodule

// File: rtl/rsop_latch.sv
module rsop_latch #(
  parameter int NIB_W = 4,
  parameter int DEPTH = 16,
  localparam int WORD_W = NIB_W * DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ev,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] hold_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (load_ev) hold_q <= din;
  end

  // R2
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> hold_q == $past(din));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable(hold_q));

endmodule

// File: rtl/rsop_rotor.sv
module rsop_rotor #(
  parameter int NIB_W = 4,
  parameter int DEPTH = 16,
  localparam int WORD_W = NIB_W * DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_ev,
  input  logic              shift_ev,
  input  logic [WORD_W-1:0] hold,
  output logic [NIB_W-1:0]  head
);
  logic [WORD_W-1:0] stage_q;
  logic              rotate_ev;
  logic              idle_ev;

  // A transfer overrides a shift seen in the same cycle.
  assign rotate_ev = shift_ev && !xfer_ev;
  assign idle_ev   = !shift_ev && !xfer_ev;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    localparam int SRC = rsop_pkg::ring_src(i, DEPTH);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage_q[i*NIB_W +: NIB_W] <= '0;
      else if (xfer_ev)
        stage_q[i*NIB_W +: NIB_W] <= hold[i*NIB_W +: NIB_W];
      else if (rotate_ev)
        stage_q[i*NIB_W +: NIB_W] <= stage_q[SRC*NIB_W +: NIB_W];
    end
  end

  assign head = stage_q[NIB_W-1:0];

  // R4
  xfer_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ev |=> head == $past(hold[NIB_W-1:0]));

  // R5
  shift_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rotate_ev |=> head == $past(stage_q[2*NIB_W-1:NIB_W]));

  // R6
  ring_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rotate_ev |=> $countones(stage_q) == $past($countones(stage_q)));

  // R9
  ring_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_ev |=> $stable(stage_q));

endmodule

// File: rtl/recirc_serial_outport.sv
module recirc_serial_outport #(
  parameter int NIB_W = 4,
  parameter int DEPTH = 16,
  localparam int WORD_W = NIB_W * DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] mem_word,
  input  logic              ram_en,
  input  logic              port_sel,
  input  logic              xfer_n,
  input  logic              shift_clk,
  input  logic              oe_n,
  output logic [NIB_W-1:0]  nib_out,
  output logic              nib_valid
);
  logic              ram_fall_ev;
  logic              xfer_ev;
  logic              shift_ev;
  logic              load_ev;
  logic [WORD_W-1:0] hold_w;
  logic [NIB_W-1:0]  head_w;

  rsop_edge #(.RISING(1'b0)) u_ram_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ram_en), .ev(ram_fall_ev));

  rsop_edge #(.RISING(1'b0)) u_xfer_edge (
    .clk(clk), .rst_n(rst_n), .lvl(xfer_n), .ev(xfer_ev));

  rsop_edge #(.RISING(1'b1)) u_shift_edge (
    .clk(clk), .rst_n(rst_n), .lvl(shift_clk), .ev(shift_ev));

  assign load_ev = ram_fall_ev && port_sel;

  rsop_latch #(.NIB_W(NIB_W), .DEPTH(DEPTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev),
    .din(mem_word), .hold_q(hold_w));

  rsop_rotor #(.NIB_W(NIB_W), .DEPTH(DEPTH)) u_rotor (
    .clk(clk), .rst_n(rst_n), .xfer_ev(xfer_ev), .shift_ev(shift_ev),
    .hold(hold_w), .head(head_w));

  assign nib_valid = !oe_n;
  assign nib_out   = oe_n ? '0 : head_w;

endmodule

// File: tb/recirc_serial_outport_bench.sv
`timescale 1ns/1ps
module recirc_serial_outport_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] mem_word = '0;
  logic        ram_en = 1'b1;
  logic        port_sel = 1'b0;
  logic        xfer_n = 1'b1;
  logic        shift_clk = 1'b0;
  logic        oe_n = 1'b0;
  logic [3:0]  nib_out;
  logic        nib_valid;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [63:0] W1 = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] W2 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] W3 = 64'h5A3C_96E1_0F7B_D248;

  always #4 clk = ~clk;

  recirc_serial_outport u_recirc_serial_outport (
    .clk(clk), .rst_n(rst_n), .mem_word(mem_word), .ram_en(ram_en),
    .port_sel(port_sel), .xfer_n(xfer_n), .shift_clk(shift_clk),
    .oe_n(oe_n), .nib_out(nib_out), .nib_valid(nib_valid));

  function automatic logic [3:0] nib_of(input logic [63:0] w, input int k);
    return 4'((w >> (4 * (k % 16))) & 64'hF);
  endfunction

  task automatic check(input string req, input logic [3:0] act,
                       input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load(input logic [63:0] w, input logic sel);
    mem_word = w; port_sel = sel; step();
    ram_en = 1'b0; step();
    ram_en = 1'b1; port_sel = 1'b0; step();
  endtask

  task automatic xfer();
    xfer_n = 1'b0; step();
    xfer_n = 1'b1; step();
  endtask

  task automatic shift();
    shift_clk = 1'b1; step();
    shift_clk = 1'b0; step();
  endtask

  // R1, R11: reset state, with strobes already active at release
  task automatic t_reset();
    shift_clk = 1'b1; xfer_n = 1'b0;
    step(); step(); rst_n = 1'b1; step(); step();
    check("R1 out after reset", nib_out, 4'h0);
    check("R1 valid after reset", {3'b0, nib_valid}, 4'h1);
    shift_clk = 1'b0; xfer_n = 1'b1; step(); step();
  endtask

  // R2, R4, R9, R5, R6: load, transfer, full walk and wrap
  task automatic t_walk();
    load(W3, 1'b1);
    check("R9 load leaves output", nib_out, 4'h0);
    xfer();
    check("R2 R4 first nibble", nib_out, nib_of(W3, 0));
    for (int k = 1; k < 16; k++) begin
      shift();
      check("R5 nibble order", nib_out, nib_of(W3, k));
    end
    for (int k = 16; k < 20; k++) begin
      shift();
      check("R6 recirculation", nib_out, nib_of(W3, k));
    end
  endtask

  // R3, R9, R7: unselected load, decoupled load, mid-block restart
  task automatic t_restart();
    load(W1, 1'b0);
    xfer();
    check("R3 unselected load ignored", nib_out, nib_of(W3, 0));
    shift(); shift();
    load(W1, 1'b1);
    check("R9 load during block", nib_out, nib_of(W3, 2));
    xfer();
    check("R7 restart at nibble 0", nib_out, nib_of(W1, 0));
    for (int k = 1; k < 4; k++) begin
      shift();
      check("R7 after restart", nib_out, nib_of(W1, k));
    end
  endtask

  // R8: coincident transfer and shift
  task automatic t_collide();
    load(W2, 1'b1);
    shift(); shift();
    shift_clk = 1'b1; xfer_n = 1'b0; step();
    check("R8 transfer wins", nib_out, nib_of(W2, 0));
    shift_clk = 1'b0; xfer_n = 1'b1; step();
    shift();
    check("R8 next after collision", nib_out, nib_of(W2, 1));
  endtask

  // R10: disabled output, shifting continues
  task automatic t_enable();
    oe_n = 1'b1; step();
    check("R10 out zero when disabled", nib_out, 4'h0);
    check("R10 valid low when disabled", {3'b0, nib_valid}, 4'h0);
    shift(); shift();
    oe_n = 1'b0; step();
    check("R10 shifted while disabled", nib_out, nib_of(W2, 3));
    check("R10 valid restored", {3'b0, nib_valid}, 4'h1);
  endtask

  // R11: held level is one edge
  task automatic t_level();
    shift_clk = 1'b1;
    repeat (6) step();
    shift_clk = 1'b0;
    repeat (3) step();
    check("R11 held shift is one edge", nib_out, nib_of(W2, 4));
    xfer_n = 1'b0;
    repeat (2) step();
    shift();
    repeat (4) step();
    xfer_n = 1'b1; step();
    check("R11 held transfer is one edge", nib_out, nib_of(W2, 1));
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    report();
  end

  initial begin
    t_reset();
    t_walk();
    t_restart();
    t_collide();
    t_enable();
    t_level();
    report();
  end

endmodule